// File: doc/BRIEF.md
# Bus Wait-State Sequencer

This block sets how many bus clock periods each bus access lasts. When an access request is accepted, it works out which region the access targets: the on-chip peripheral register space, internal memory, or one of four external chip-select regions. It then reads the wait settings that apply to that region, the bus mode (separate or multiplexed address/data), the direction and the clock-source state. It raises its strobe for the chosen number of bus clocks and pulses `done` on the last one.

The request side is a valid/ready handshake. `acc_ready` is high only while no access is in progress. A request is taken on a clock edge where `acc_valid` and `acc_ready` are both high. While the strobe is active, `acc_ready` stays low and the requester must hold or withdraw its request. Nothing presented during that time has any effect. The region code, direction, mode flags and configuration bits are sampled on the accepting edge only.

A setting that breaks a mandatory rule raises `cfg_err` for the whole access. The rule is a region marked no-wait while the bus is multiplexed or the global wait bit is set. In that case the access runs with one wait.

Top module: `bus_wait_seq`

## Requirements
- R1: While `rst_n` is low, `strobe`, `done` and `cfg_err` are 0 and `acc_ready` is 1.
- R2: `acc_ready` is the inverse of `strobe`. An accepted request raises `strobe` on the next cycle. Requests and input changes while `strobe` is high have no effect on the access in progress.
- R3: Region codes 1, 2 and 3 select internal memory. These accesses last 1 clock when `glob_wait` is 0 and 2 clocks when it is 1.
- R4: Region code 0 selects the peripheral register space. These accesses last 3 clocks when `pll_src`=1 and `sfr_fast`=0, and 2 clocks otherwise.
- R5: Region codes 4+i select external region i. On a separate bus, with `glob_wait`=0 and `area_nowait[i]`=1, a read lasts 1 clock and a write lasts 2 clocks.
- R6: On a separate bus with `area_nowait[i]`=0, the wait field `area_wcnt[2i+1:2i]` sets the number of waits. Code 00 gives 1 wait, 01 gives 2, and 10 or 11 give 3. The access lasts the number of waits plus 1 clock.
- R7: On a multiplexed bus (`mux_bus`=1) with `area_nowait[i]`=0, 1 wait gives 3 clocks, 2 waits give 3 clocks and 3 waits give 4 clocks.
- R8: If `area_nowait[i]`=1 and either `mux_bus` or `glob_wait` is 1, `cfg_err` is high for every strobe cycle of the access. The access then uses one wait: 2 clocks on a separate bus and 3 clocks on a multiplexed bus. `cfg_err` is 0 at all other times.
- R9: `done` is high for exactly one cycle, the last strobe cycle. `strobe` is low on the following cycle, and a new request can be accepted on that cycle.
- R10: With every configuration input at 0, a separate-bus external access lasts 2 clocks and an internal access lasts 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Sequencer idle, request can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_area | input | 3 | Region code: 0 registers, 1-3 internal, 4+i external region i |
| mux_bus | input | 1 | 1 = multiplexed external bus |
| pll_src | input | 1 | CPU clock is taken from the PLL |
| sfr_fast | input | 1 | Short register cycle while on the PLL clock |
| glob_wait | input | 1 | Global wait bit |
| area_nowait | input | 4 | Per external region: 1 = no-wait operation |
| area_wcnt | input | 8 | Per external region 2-bit wait code, region i at bits 2i+1:2i |
| strobe | output | 1 | Access cycle in progress |
| done | output | 1 | Last cycle of the access |
| cfg_err | output | 1 | Current access uses a forbidden setting |

## Verification
Two functions can fall in the same cycle: the `done` cycle of one access, and a request that stays valid across it. `done` and `cfg_err` can also be high in the same cycle. The bench holds `acc_valid` high through back-to-back accesses, including ones with a forbidden setting. A reference model judges each cycle. It expects the held request to be ignored on the `done` cycle and taken one cycle later, and it expects `cfg_err` to drop together with the strobe.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    RK_REG = 2'd0,
    RK_INT = 2'd1,
    RK_EXT = 2'd2
  } region_kind_e;
endpackage

// File: rtl/bws_region_decode.sv
module bws_region_decode
  import bws_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int CS_N   = 4,
  localparam int CS_IW = $clog2(CS_N)
) (
  input  logic [AREA_W-1:0] area,
  output region_kind_e      kind,
  output logic [CS_IW-1:0]  cs_idx
);
  always_comb begin
    cs_idx = area[CS_IW-1:0];
    if (area[AREA_W-1])   kind = RK_EXT;
    else if (area == '0)  kind = RK_REG;
    else                  kind = RK_INT;
  end
endmodule

// File: rtl/bws_len_calc.sv
module bws_len_calc
  import bws_pkg::*;
#(
  parameter int CS_N      = 4,
  parameter int WC_W      = 2,
  parameter int MAX_WAITS = 3,
  parameter int LEN_W     = 3,
  localparam int CS_IW    = $clog2(CS_N)
) (
  input  region_kind_e         kind,
  input  logic [CS_IW-1:0]     cs_idx,
  input  logic                 write,
  input  logic                 mux_bus,
  input  logic                 pll_src,
  input  logic                 sfr_fast,
  input  logic                 glob_wait,
  input  logic [CS_N-1:0]      nowait,
  input  logic [CS_N*WC_W-1:0] wcnt,
  output logic [LEN_W-1:0]     len,
  output logic                 bad
);
  localparam logic [LEN_W-1:0] MUX_MIN = LEN_W'(3);
  localparam logic [LEN_W-1:0] WMAX    = LEN_W'(MAX_WAITS);

  logic [WC_W-1:0] wc_arr [CS_N];

  genvar gi;
  generate
    for (gi = 0; gi < CS_N; gi++) begin : g_field
      assign wc_arr[gi] = wcnt[gi*WC_W +: WC_W];
    end
  endgenerate

  logic            sel_nw;
  logic [WC_W-1:0] sel_wc;
  logic [LEN_W-1:0] waits, cyc;

  always_comb begin
    sel_nw = nowait[cs_idx];
    sel_wc = wc_arr[cs_idx];
    if ((LEN_W'(sel_wc) + LEN_W'(1)) > WMAX) waits = WMAX;
    else                                     waits = LEN_W'(sel_wc) + LEN_W'(1);
  end

  always_comb begin
    bad = 1'b0;
    cyc = '0;
    len = '0;
    unique case (kind)
      RK_REG: len = (pll_src && !sfr_fast) ? LEN_W'(3) : LEN_W'(2);
      RK_INT: len = glob_wait ? LEN_W'(2) : LEN_W'(1);
      default: begin
        if (sel_nw && !mux_bus && !glob_wait) begin
          len = write ? LEN_W'(2) : LEN_W'(1);
        end else begin
          bad = sel_nw;
          cyc = sel_nw ? LEN_W'(2) : (waits + LEN_W'(1));
          if (mux_bus && cyc < MUX_MIN) len = MUX_MIN;
          else                          len = cyc;
        end
      end
    endcase
  end
endmodule

// File: rtl/bws_counter.sv
module bws_counter #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_err,
  output logic             busy,
  output logic             last,
  output logic             err
);
  logic [LEN_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_len;
      err_q <= load_err;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == LEN_W'(1));
  assign err  = err_q & busy;
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int AREA_W    = 3,
  parameter int CS_N      = 4,
  parameter int WC_W      = 2,
  parameter int MAX_WAITS = 3,
  parameter int LEN_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic                 acc_write,
  input  logic [AREA_W-1:0]    acc_area,
  input  logic                 mux_bus,
  input  logic                 pll_src,
  input  logic                 sfr_fast,
  input  logic                 glob_wait,
  input  logic [CS_N-1:0]      area_nowait,
  input  logic [CS_N*WC_W-1:0] area_wcnt,
  output logic                 strobe,
  output logic                 done,
  output logic                 cfg_err
);
  localparam int CS_IW = $clog2(CS_N);

  region_kind_e     kind;
  logic [CS_IW-1:0] cs_idx;
  logic [LEN_W-1:0] len;
  logic             bad, busy, load;

  bws_region_decode #(.AREA_W(AREA_W), .CS_N(CS_N)) u_dec (
    .area(acc_area), .kind(kind), .cs_idx(cs_idx)
  );

  bws_len_calc #(.CS_N(CS_N), .WC_W(WC_W), .MAX_WAITS(MAX_WAITS), .LEN_W(LEN_W)) u_len (
    .kind(kind), .cs_idx(cs_idx), .write(acc_write), .mux_bus(mux_bus),
    .pll_src(pll_src), .sfr_fast(sfr_fast), .glob_wait(glob_wait),
    .nowait(area_nowait), .wcnt(area_wcnt), .len(len), .bad(bad)
  );

  assign acc_ready = !busy;
  assign load      = acc_valid && acc_ready;

  bws_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_len(len), .load_err(bad),
    .busy(busy), .last(done), .err(cfg_err)
  );

  assign strobe = busy;
endmodule

// File: rtl/bws_checker.sv
module bws_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_ready,
  input logic strobe,
  input logic done,
  input logic cfg_err
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!strobe && !done && !cfg_err && acc_ready)
        else $error("R1 outputs not idle in reset");
    end
  end

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> strobe) else $error("R2 accept without strobe");

  p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !done) |=> strobe) else $error("R2 strobe dropped early");

  p_done_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> strobe) else $error("R9 done outside strobe");

  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!strobe && !done && acc_ready)) else $error("R9 strobe after done");

  p_err_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> strobe) else $error("R8 cfg_err outside access");
endmodule

bind bus_wait_seq bws_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .strobe(strobe), .done(done), .cfg_err(cfg_err)
);

// File: tb/sim_bus_wait_seq.sv
module sim_bus_wait_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_area = '0;
  logic       mux_bus = 1'b0, pll_src = 1'b0, sfr_fast = 1'b0, glob_wait = 1'b0;
  logic [3:0] area_nowait = '0;
  logic [7:0] area_wcnt = '0;
  logic       acc_ready, strobe, done, cfg_err;

  int checks = 0, failures = 0, cycles = 0;

  // reference model state
  int    rem = 0;
  bit    exp_bad = 0;
  int    cur_len = 0;
  string cur_tag = "R1";
  string next_tag = "R2";
  int    run_cnt = 0;

  always #10 clk = ~clk;

  bus_wait_seq u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_area(acc_area), .mux_bus(mux_bus),
    .pll_src(pll_src), .sfr_fast(sfr_fast), .glob_wait(glob_wait),
    .area_nowait(area_nowait), .area_wcnt(area_wcnt),
    .strobe(strobe), .done(done), .cfg_err(cfg_err)
  );

  function automatic int ref_len(int area, bit wr, bit mx, bit gw, bit pl, bit fs,
                                 bit nw, int wc);
    int w;
    if (area == 0) return (pl && !fs) ? 3 : 2;
    if (area < 4) return gw ? 2 : 1;
    if (nw && !mx && !gw) return wr ? 2 : 1;
    if (nw) w = 1;
    else    w = (wc >= 2) ? 3 : wc + 1;
    if (mx && w < 2) return 3;
    return w + 1;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // model update at the active edge (reads only bench-driven inputs)
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      rem = 0; exp_bad = 0;
    end else if (rem > 0) begin
      rem--;
    end else if (acc_valid) begin
      int a, nw, wc;
      a  = int'(acc_area);
      nw = (a >= 4) ? int'(area_nowait[a-4]) : 0;
      wc = (a >= 4) ? int'(area_wcnt[2*(a-4) +: 2]) : 0;
      rem = ref_len(a, acc_write, mux_bus, glob_wait, pll_src, sfr_fast, nw[0], wc);
      exp_bad = (a >= 4) && (nw != 0) && (mux_bus || glob_wait);
      cur_len = rem;
      cur_tag = next_tag;
    end
  end

  // comparison away from the edge
  always @(negedge clk) begin
    string t;
    t = !rst_n ? "R1" : (rem > 0 ? cur_tag : "R2");
    check(strobe == (rem > 0), t, "strobe", strobe, rem > 0);
    check(acc_ready == (rem == 0), t, "acc_ready", acc_ready, rem == 0);
    check(done == (rem == 1), (rem > 0) ? "R9" : t, "done", done, rem == 1);
    check(cfg_err == (rem > 0 && exp_bad), (exp_bad ? "R8" : t), "cfg_err",
          cfg_err, rem > 0 && exp_bad);
    if (strobe) run_cnt++;
    if (strobe && done) begin
      check(run_cnt == cur_len, cur_tag, "strobe length", run_cnt, cur_len);
      run_cnt = 0;
    end else if (!strobe) run_cnt = 0;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (rem > 0) @(negedge clk);
  endtask

  task automatic one_access(int area, bit wr, bit mx, bit gw, bit pl, bit fs,
                            bit nw, int wc, string tag);
    @(negedge clk);
    acc_area  = 3'(area);
    acc_write = wr;
    mux_bus   = mx;
    glob_wait = gw;
    pll_src   = pl;
    sfr_fast  = fs;
    area_nowait = {4{~nw}};
    area_wcnt   = {4{~2'(wc)}};
    if (area >= 4) begin
      area_nowait[area-4] = nw;
      area_wcnt[2*(area-4) +: 2] = 2'(wc);
    end
    next_tag = tag;
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_area  = ~acc_area;   // changes while busy must be ignored (R2)
    acc_write = ~acc_write;
    mux_bus   = ~mux_bus;
    wait_idle();
  endtask

  initial begin
    // R1: reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: all configuration zero
    one_access(4, 0, 0, 0, 0, 0, 0, 0, "R10");
    one_access(6, 1, 0, 0, 0, 0, 0, 0, "R10");
    one_access(2, 0, 0, 0, 0, 0, 0, 0, "R10");

    // full sweep
    for (int a = 0; a < 8; a++)
      for (int wr = 0; wr < 2; wr++)
        for (int mx = 0; mx < 2; mx++)
          for (int gw = 0; gw < 2; gw++)
            for (int pl = 0; pl < 2; pl++)
              for (int fs = 0; fs < 2; fs++)
                for (int nw = 0; nw < 2; nw++)
                  for (int wc = 0; wc < 4; wc++) begin
                    string tg;
                    if (a == 0) tg = "R4";
                    else if (a < 4) tg = "R3";
                    else if (nw != 0 && (mx != 0 || gw != 0)) tg = "R8";
                    else if (mx != 0) tg = "R7";
                    else if (nw != 0) tg = "R5";
                    else tg = "R6";
                    one_access(a, wr[0], mx[0], gw[0], pl[0], fs[0], nw[0], wc, tg);
                  end

    // R2/R9: request held valid across done, back-to-back, incl. error accesses
    @(negedge clk);
    next_tag = "R9";
    acc_area = 3'd5; mux_bus = 1'b1; glob_wait = 1'b0;
    area_nowait = 4'b0010; area_wcnt = 8'h00;
    acc_valid = 1'b1;
    repeat (20) @(negedge clk);
    acc_area = 3'd7; mux_bus = 1'b0; area_nowait = 4'b0000; area_wcnt = 8'hC0;
    next_tag = "R2";
    repeat (20) @(negedge clk);
    acc_valid = 1'b0;
    wait_idle();

    // reset in mid-access returns to idle (R1)
    @(negedge clk);
    next_tag = "R1";
    acc_area = 3'd4; mux_bus = 1'b1; area_wcnt = 8'h03; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule